// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits beside a simple in-order core and decides which interrupt vector the core enters next. Every source has a sticky pending flag that an event pulse sets. A flag stays set until the source is serviced or software cancels it, so a request that cannot be served at once is kept rather than dropped. Arbitration happens only at instruction boundaries, which the core signals with a strobe. At a boundary the block picks the eligible source with the smallest vector index and raises a one-cycle vector request that carries that index.

A single global enable gates every maskable source. The controller clears it by itself when it accepts a vector, so handlers do not nest unless software turns the enable back on. A return indication from the core sets the enable again, and so does a software write. After any 0-to-1 change of the enable, one further boundary passes before a maskable source can win. This lets the instruction that follows the enable finish, which makes an enable-then-sleep pair safe. Vector 0 stands for the reset request and ignores both the global enable and its own enable bit.

Top module: `fp_vic`

## Requirements
- R1: After reset every pending flag is 0, the global enable `gie_o` is 0 and `take_o` is 0.
- R2: A 1 on `evt_i[k]` sets `pend_o[k]` at the next clock edge. The flag then stays 1 across any number of cycles until it is serviced or cleared.
- R3: `take_o` is high for exactly the cycle after a cycle in which `boundary_i` was high and at least one source was eligible. It is never high at any other time.
- R4: When several sources are eligible, `take_idx_o` is the smallest eligible index, whatever order the events arrived in.
- R5: Source k > 0 is eligible only when `pend_o[k]`, `src_en_i[k]` and the effective global enable are all 1. A source that is not eligible keeps its pending flag.
- R6: Source 0 is eligible whenever `pend_o[0]` is 1, even with `gie_o` at 0, with `src_en_i[0]` at 0, or inside the one-boundary hold-off.
- R7: In the cycle that `take_o` is high, `gie_o` is 0 and the pending flag of the taken source is 0, unless a new event hit that source in the accepting cycle.
- R8: A cycle with `reti_i` high and no accept and no enable-clear write makes `gie_o` 1 from the next cycle on.
- R9: After `gie_o` changes from 0 to 1, the first boundary strobe accepts no source other than 0. The second boundary can accept one.
- R10: A write (`wr_valid_i` high) clears every pending flag whose bit is 1 in `wr_clr_pend_i`. With `wr_gie_set_i` it sets the enable, and with `wr_gie_clr_i` it clears the enable; the clear wins over the set.
- R11: If an event arrives on a source in the same cycle that its flag is cleared, whether by a write or by an accept, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_SRC | Event pulses, one per source; bit 0 is the reset request |
| src_en_i | input | NUM_SRC | Per-source enable bits |
| wr_valid_i | input | 1 | Register write strobe |
| wr_clr_pend_i | input | NUM_SRC | Pending flags to cancel on a write |
| wr_gie_set_i | input | 1 | Write sets the global enable |
| wr_gie_clr_i | input | 1 | Write clears the global enable |
| reti_i | input | 1 | Return-from-interrupt indication from the core |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| take_o | output | 1 | Vector request, one cycle |
| take_idx_o | output | $clog2(NUM_SRC) | Index of the requested vector |
| gie_o | output | 1 | Global interrupt enable |
| pend_o | output | NUM_SRC | Pending flags |

## Verification
Two pairs of functions can fall on the same edge. A new event can collide with the clearing of that same flag, and an enable rise can coincide with a boundary strobe. The bench provokes the first pair by pulsing an event together with a cancel write, and again together with the boundary that accepts that source. It then judges from `pend_o` that the flag survived. It provokes the second pair by setting the enable, or returning from a handler, with a source already pending. It then checks that `take_o` stays low on the first boundary and rises with the right index on the second.

// File: rtl/fp_vic.sv
module fp_vic #(
  parameter int NUM_SRC = 26
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           evt_i,
  input  logic [NUM_SRC-1:0]           src_en_i,
  input  logic                         wr_valid_i,
  input  logic [NUM_SRC-1:0]           wr_clr_pend_i,
  input  logic                         wr_gie_set_i,
  input  logic                         wr_gie_clr_i,
  input  logic                         reti_i,
  input  logic                         boundary_i,
  output logic                         take_o,
  output logic [$clog2(NUM_SRC)-1:0]   take_idx_o,
  output logic                         gie_o,
  output logic [NUM_SRC-1:0]           pend_o
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pend_q, cand, grant_mask, clr_mask;
  logic               gie_q, gie_d, shadow_q, take_q, win_any, fire, gie_ok;
  logic [IDX_W-1:0]   idx_q, win_idx;

  assign gie_ok = gie_q & ~shadow_q;
  assign cand   = (pend_q & src_en_i & {NUM_SRC{gie_ok}})
                | {{(NUM_SRC-1){1'b0}}, pend_q[0]};

  always_comb begin
    win_any = 1'b0;
    win_idx = '0;
    for (int i = NUM_SRC-1; i >= 0; i--) begin
      if (cand[i]) begin
        win_any = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

  assign fire       = boundary_i & win_any;
  assign grant_mask = fire ? (NUM_SRC'(1) << win_idx) : '0;
  assign clr_mask   = (wr_valid_i ? wr_clr_pend_i : '0) | grant_mask;

  always_comb begin
    gie_d = gie_q;
    if (fire || (wr_valid_i && wr_gie_clr_i))
      gie_d = 1'b0;
    else if (reti_i || (wr_valid_i && wr_gie_set_i))
      gie_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      gie_q    <= 1'b0;
      shadow_q <= 1'b0;
      take_q   <= 1'b0;
      idx_q    <= '0;
    end else begin
      pend_q   <= (pend_q & ~clr_mask) | evt_i;
      gie_q    <= gie_d;
      if (!gie_q && gie_d)
        shadow_q <= 1'b1;
      else if (boundary_i)
        shadow_q <= 1'b0;
      take_q   <= fire;
      if (fire)
        idx_q  <= win_idx;
    end
  end

  assign take_o     = take_q;
  assign take_idx_o = idx_q;
  assign gie_o      = gie_q;
  assign pend_o     = pend_q;
endmodule

// File: rtl/fp_vic_chk.sv
module fp_vic_chk #(
  parameter int NUM_SRC = 26
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_SRC-1:0]           evt_i,
  input logic                         wr_valid_i,
  input logic                         wr_gie_clr_i,
  input logic                         reti_i,
  input logic                         boundary_i,
  input logic                         take_o,
  input logic [$clog2(NUM_SRC)-1:0]   take_idx_o,
  input logic                         gie_o,
  input logic [NUM_SRC-1:0]           pend_o
);
  logic [NUM_SRC-1:0] evt_q;
  logic gie_prev, arm_q, rise_now, blocked;

  assign rise_now = gie_o & ~gie_prev;
  assign blocked  = boundary_i & (arm_q | rise_now);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q    <= '0;
      gie_prev <= 1'b0;
      arm_q    <= 1'b0;
    end else begin
      evt_q    <= evt_i;
      gie_prev <= gie_o;
      arm_q    <= (arm_q | rise_now) & ~boundary_i;
    end
  end

  p_take_at_boundary_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));

  p_take_drops_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !gie_o);

  p_taken_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (!pend_o[take_idx_o] || evt_q[take_idx_o]));

  p_event_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((pend_o & evt_q) == evt_q));

  p_reti_enables_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !boundary_i && !(wr_valid_i && wr_gie_clr_i)) |=> gie_o);

  p_gie_clear_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && wr_gie_clr_i) |=> !gie_o);

  p_reset_unmaskable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && pend_o[0]) |=> (take_o && take_idx_o == '0));

  p_holdoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> (!take_o || take_idx_o == '0));
endmodule

bind fp_vic fp_vic_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_valid_i(wr_valid_i),
  .wr_gie_clr_i(wr_gie_clr_i), .reti_i(reti_i), .boundary_i(boundary_i),
  .take_o(take_o), .take_idx_o(take_idx_o), .gie_o(gie_o), .pend_o(pend_o)
);

// File: tb/fp_vic_tb.sv
module fp_vic_tb;
  localparam int N  = 26;
  localparam int IW = $clog2(N);
  localparam int NV = 8;
  localparam logic [N-1:0] ALL = {N{1'b1}};

  localparam logic [N-1:0] T_EVT [NV] = '{26'h0100088, 26'h2000400, 26'h0000024, 26'h0000200,
                                          26'h0000006, 26'h0000010, 26'h2000000, 26'h0007000};
  localparam logic [N-1:0] T_EN  [NV] = '{26'h3FFFFFF, 26'h3FFFFFF, 26'h3FFFFFB, 26'h3FFFFFF,
                                          26'h3FFFFFF, 26'h0000000, 26'h3FFFFFF, 26'h0004000};
  localparam logic         T_GIE [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic         T_TAK [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam int           T_IDX [NV] = '{3, 10, 5, 0, 1, 0, 25, 14};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] evt_i = '0, src_en_i = '0, wr_clr_pend_i = '0;
  logic wr_valid_i = 1'b0, wr_gie_set_i = 1'b0, wr_gie_clr_i = 1'b0;
  logic reti_i = 1'b0, boundary_i = 1'b0;
  logic take_o, gie_o;
  logic [IW-1:0] take_idx_o;
  logic [N-1:0] pend_o;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  fp_vic #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .src_en_i(src_en_i),
    .wr_valid_i(wr_valid_i), .wr_clr_pend_i(wr_clr_pend_i),
    .wr_gie_set_i(wr_gie_set_i), .wr_gie_clr_i(wr_gie_clr_i),
    .reti_i(reti_i), .boundary_i(boundary_i), .take_o(take_o),
    .take_idx_o(take_idx_o), .gie_o(gie_o), .pend_o(pend_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [N-1:0] clr, input logic set, input logic off);
    wr_valid_i = 1'b1; wr_clr_pend_i = clr; wr_gie_set_i = set; wr_gie_clr_i = off;
    step();
    wr_valid_i = 1'b0; wr_clr_pend_i = '0; wr_gie_set_i = 1'b0; wr_gie_clr_i = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    evt_i = m; step(); evt_i = '0;
  endtask

  task automatic bnd();
    boundary_i = 1'b1; step(); boundary_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R3 watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 pend after reset", 32'(pend_o), 0);
    check("R1 gie after reset", 32'(gie_o), 0);
    check("R1 take after reset", 32'(take_o), 0);

    for (int v = 0; v < NV; v++) begin
      wr(ALL, 1'b0, 1'b1);
      src_en_i = T_EN[v];
      pulse(T_EVT[v]);
      check($sformatf("R2 vec%0d latched", v), 32'(pend_o), 32'(T_EVT[v]));
      if (T_GIE[v]) begin
        wr('0, 1'b1, 1'b0);
        bnd();
        check($sformatf("R9 vec%0d hold-off", v), 32'(take_o), 0);
      end
      bnd();
      check($sformatf("R4 R5 vec%0d take", v), 32'(take_o), 32'(T_TAK[v]));
      if (T_TAK[v]) begin
        check($sformatf("R4 vec%0d index", v), 32'(take_idx_o), 32'(T_IDX[v]));
        check($sformatf("R7 vec%0d gie", v), 32'(gie_o), 0);
        check($sformatf("R7 vec%0d pend", v), 32'(pend_o),
              32'(T_EVT[v] & ~(N'(1) << T_IDX[v])));
      end else begin
        check($sformatf("R5 vec%0d pend kept", v), 32'(pend_o), 32'(T_EVT[v]));
        check($sformatf("R5 vec%0d gie", v), 32'(gie_o), 32'(T_GIE[v]));
      end
      step();
      check($sformatf("R3 vec%0d single pulse", v), 32'(take_o), 0);
    end

    wr(ALL, 1'b0, 1'b1);
    src_en_i = '0;
    pulse(N'(1));
    bnd();
    check("R6 reset source taken", 32'(take_o), 1);
    check("R6 reset index", 32'(take_idx_o), 0);
    check("R6 pend cleared", 32'(pend_o), 0);
    step();

    src_en_i = ALL;
    pulse(N'(1) << 6);
    wr('0, 1'b1, 1'b0);
    check("R10 gie set by write", 32'(gie_o), 1);
    repeat (4) step();
    check("R3 no take without boundary", 32'(take_o), 0);
    check("R2 flag persists", 32'(pend_o), 32'(N'(1) << 6));
    bnd();
    check("R9 first boundary blocked", 32'(take_o), 0);
    bnd();
    check("R9 second boundary takes", 32'(take_o), 1);
    check("R9 index", 32'(take_idx_o), 6);
    step();

    pulse(N'(1) << 8);
    reti_i = 1'b1; step(); reti_i = 1'b0;
    check("R8 reti sets gie", 32'(gie_o), 1);
    bnd();
    check("R9 blocked after reti", 32'(take_o), 0);
    bnd();
    check("R9 taken after reti", 32'(take_idx_o), 8);
    check("R3 take after reti", 32'(take_o), 1);
    step();

    pulse(N'(1) << 11);
    wr(N'(1) << 11, 1'b0, 1'b0);
    check("R10 write cancels flag", 32'(pend_o), 0);
    pulse(N'(1) << 11);
    evt_i = N'(1) << 11;
    wr(N'(1) << 11, 1'b0, 1'b0);
    evt_i = '0;
    check("R11 event beats write clear", 32'(pend_o), 32'(N'(1) << 11));
    wr(ALL, 1'b1, 1'b1);
    check("R10 clear wins over set", 32'(gie_o), 0);
    check("R10 clear all", 32'(pend_o), 0);

    pulse(N'(1) << 7);
    wr('0, 1'b1, 1'b0);
    bnd();
    evt_i = N'(1) << 7;
    bnd();
    evt_i = '0;
    check("R11 take with same-cycle event", 32'(take_idx_o), 7);
    check("R11 flag re-armed", 32'(pend_o), 32'(N'(1) << 7));
    step();

    pulse(N'(1) << 2);
    src_en_i = ALL;
    pulse(N'(1) << 1);
    wr('0, 1'b1, 1'b0);
    bnd();
    bnd();
    check("R4 lower index wins over arrival", 32'(take_idx_o), 1);
    step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule